// File: doc/BRIEF.md
# Sampled Shadow-Tag Contention Detector

This block watches the access stream of a shared cache and estimates, per application, how many of its shared-cache misses are caused by other applications crowding it out. For each application it keeps a private shadow tag directory that behaves as if that application owned the whole cache: same associativity, least-recently-used replacement, filled only by that application's own accesses. A shared-cache miss whose tag is still held in the requester's shadow directory is a contention miss and bumps that application's counter.

To keep storage small, only a fixed fraction of the cache sets is shadowed: a set is sampled when the low `SAMPLE_BITS` bits of its index are all zero, and every other access is dropped on entry. Each raw counter is read out multiplied by the sampling ratio (a left shift by `SAMPLE_BITS`) as an estimate for the whole cache. A one-cycle interval strobe zeroes all counters at the end of each measurement window while the shadow directories carry on.

Accesses move through a two-state controller. `ST_IDLE` holds no pending work; a sampled access moves it to `ST_APPLY` (transition *accept*), in which the registered access is looked up and written into the shadow directory. From `ST_APPLY` a further sampled access keeps it in `ST_APPLY` (*chain*), otherwise it returns to `ST_IDLE` (*drain*). An unsampled access or no access in `ST_IDLE` leaves it in `ST_IDLE` (*hold*).

Top module: `contention_tagdir`

## Requirements
- R1: After reset every counter output reads 0 and every shadow directory is empty (no tag of any application hits).
- R2: An access whose set index has any of its low `SAMPLE_BITS` bits set (default: `acc_set[1:0] != 0`) changes neither any counter nor any shadow directory.
- R3: A sampled access with `acc_shared_miss = 1` whose tag is present in the requesting application's shadow set adds one to that application's counter.
- R4: A sampled access counts nothing if `acc_shared_miss = 0` (shared hit) or if its tag is absent from the shadow set.
- R5: Each application has its own shadow directory and counter; an access by one application never hits in, nor counts for, another.
- R6: Every sampled access, hit or miss in the shared cache, updates its shadow set with LRU order: a present tag becomes most recent; an absent tag replaces the least recently used way (empty ways are used first).
- R7: Output lane i, `contention_cnt[i*OUT_W +: OUT_W]`, equals raw counter i shifted left by `SAMPLE_BITS` (default lane width 8 bits, application 0 in bits [7:0]).
- R8: A raw counter stops at 2^`CNT_W`-1 (default 63, read as 252) and does not wrap.
- R9: `interval_clr` zeroes all counters at the next edge without touching the shadow directories; a contention miss applied in that same cycle leaves the counter at 1.
- R10: An access presented at edge k shows in the counters after edge k+1, and a new access is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An observed shared-cache access is present |
| acc_app | input | APP_W | Requesting application number |
| acc_set | input | SET_BITS | Shared-cache set index |
| acc_tag | input | TAG_W | Address tag |
| acc_shared_miss | input | 1 | 1 when the shared cache missed |
| interval_clr | input | 1 | One-cycle strobe that zeroes all counters |
| contention_cnt | output | NUM_APPS*OUT_W | Scaled contention-miss counts, one lane per application |

## Verification
An access driven before edge k is registered at that edge and applied to the directory and counters at edge k+1, so every check samples the counters on the falling edge after that second edge; the latency test also samples after the first edge to see no change yet. A clear strobe takes effect at its own edge and is sampled on the following falling edge, including the case where it lands on the apply edge of a counted access. The saturation run holds an access valid every cycle, so it also confirms the one-per-cycle acceptance.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } ctd_state_e;

endpackage

// File: rtl/ctd_way_lookup.sv
module ctd_way_lookup #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 8,
    parameter int RANK_W = 2,
    parameter int WAY_W  = 2
) (
    input  logic [WAYS*TAG_W-1:0]  tags_flat,
    input  logic [WAYS-1:0]        vld,
    input  logic [WAYS*RANK_W-1:0] rank_flat,
    input  logic [TAG_W-1:0]       tag,
    output logic [WAYS-1:0]        hit_vec,
    output logic                   hit,
    output logic [WAY_W-1:0]       touch_way,
    output logic [WAYS*RANK_W-1:0] next_rank_flat
);

    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim_way;
    logic [RANK_W-1:0] touch_rank;

    always_comb begin
        hit_way    = '0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vld[w] && (tags_flat[w*TAG_W +: TAG_W] == tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (rank_flat[w*RANK_W +: RANK_W] == OLDEST) victim_way = WAY_W'(w);
        end
        hit       = |hit_vec;
        touch_way = hit ? hit_way : victim_way;
    end

    always_comb begin
        touch_rank = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way) touch_rank = rank_flat[w*RANK_W +: RANK_W];
        end
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
                next_rank_flat[w*RANK_W +: RANK_W] = '0;
            else if (rank_flat[w*RANK_W +: RANK_W] < touch_rank)
                next_rank_flat[w*RANK_W +: RANK_W] = rank_flat[w*RANK_W +: RANK_W] + 1'b1;
            else
                next_rank_flat[w*RANK_W +: RANK_W] = rank_flat[w*RANK_W +: RANK_W];
        end
    end

endmodule

// File: rtl/ctd_sat_counter.sv
module ctd_sat_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (clr)
            cnt_d = CNT_W'(inc);
        else if (inc && (cnt_q != CNT_MAX))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && !clr |=> (cnt_q == CNT_MAX));

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q <= CNT_W'(1)));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/contention_tagdir.sv
module contention_tagdir #(
    parameter int NUM_APPS    = 2,
    parameter int SET_BITS    = 6,
    parameter int SAMPLE_BITS = 2,
    parameter int WAYS        = 4,
    parameter int TAG_W       = 8,
    parameter int CNT_W       = 6,
    localparam int APP_W      = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
    localparam int OUT_W      = CNT_W + SAMPLE_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic [APP_W-1:0]          acc_app,
    input  logic [SET_BITS-1:0]       acc_set,
    input  logic [TAG_W-1:0]          acc_tag,
    input  logic                      acc_shared_miss,
    input  logic                      interval_clr,
    output logic [NUM_APPS*OUT_W-1:0] contention_cnt
);

    import ctd_pkg::*;

    localparam int SSET_W = SET_BITS - SAMPLE_BITS;
    localparam int SSETS  = 1 << SSET_W;
    localparam int RANK_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WAY_W  = RANK_W;

    ctd_state_e state_q, state_d;

    logic              acc_sampled;
    logic              apply_en;
    logic [APP_W-1:0]  st_app;
    logic [SSET_W-1:0] st_sset;
    logic [TAG_W-1:0]  st_tag;
    logic              st_miss;

    logic [TAG_W-1:0]  dir_tag  [NUM_APPS][SSETS][WAYS];
    logic              dir_vld  [NUM_APPS][SSETS][WAYS];
    logic [RANK_W-1:0] dir_rank [NUM_APPS][SSETS][WAYS];

    logic [WAYS*TAG_W-1:0]  cur_tags;
    logic [WAYS-1:0]        cur_vld;
    logic [WAYS*RANK_W-1:0] cur_rank;
    logic [WAYS-1:0]        lk_hit_vec;
    logic                   lk_hit;
    logic [WAY_W-1:0]       lk_touch;
    logic [WAYS*RANK_W-1:0] lk_next_rank;
    logic                   contention;
    logic [NUM_APPS-1:0]    cnt_inc;

    assign acc_sampled = acc_valid && (acc_set[SAMPLE_BITS-1:0] == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept / chain / drain / hold
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = acc_sampled ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = acc_sampled ? ST_APPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        unique case (state_q)
            ST_APPLY: apply_en = 1'b1;
            default:  apply_en = 1'b0;
        endcase
    end

    // access capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_app  <= '0;
            st_sset <= '0;
            st_tag  <= '0;
            st_miss <= 1'b0;
        end else if (acc_sampled) begin
            st_app  <= acc_app;
            st_sset <= acc_set[SET_BITS-1:SAMPLE_BITS];
            st_tag  <= acc_tag;
            st_miss <= acc_shared_miss;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            cur_tags[w*TAG_W +: TAG_W]   = dir_tag[st_app][st_sset][w];
            cur_vld[w]                   = dir_vld[st_app][st_sset][w];
            cur_rank[w*RANK_W +: RANK_W] = dir_rank[st_app][st_sset][w];
        end
    end

    ctd_way_lookup #(
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .RANK_W (RANK_W),
        .WAY_W  (WAY_W)
    ) u_lookup (
        .tags_flat      (cur_tags),
        .vld            (cur_vld),
        .rank_flat      (cur_rank),
        .tag            (st_tag),
        .hit_vec        (lk_hit_vec),
        .hit            (lk_hit),
        .touch_way      (lk_touch),
        .next_rank_flat (lk_next_rank)
    );

    // shadow directory update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_APPS; a++)
                for (int s = 0; s < SSETS; s++)
                    for (int w = 0; w < WAYS; w++) begin
                        dir_tag[a][s][w]  <= '0;
                        dir_vld[a][s][w]  <= 1'b0;
                        dir_rank[a][s][w] <= RANK_W'(w);
                    end
        end else if (apply_en) begin
            dir_tag[st_app][st_sset][lk_touch] <= st_tag;
            dir_vld[st_app][st_sset][lk_touch] <= 1'b1;
            for (int w = 0; w < WAYS; w++)
                dir_rank[st_app][st_sset][w] <= lk_next_rank[w*RANK_W +: RANK_W];
        end
    end

    assign contention = apply_en && lk_hit && st_miss;

    generate
        for (genvar i = 0; i < NUM_APPS; i++) begin : g_app
            logic [CNT_W-1:0] raw_cnt;

            assign cnt_inc[i] = contention && (st_app == APP_W'(i));

            ctd_sat_counter #(
                .CNT_W (CNT_W)
            ) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (interval_clr),
                .inc   (cnt_inc[i]),
                .cnt   (raw_cnt)
            );

            assign contention_cnt[i*OUT_W +: OUT_W] = {raw_cnt, {SAMPLE_BITS{1'b0}}};
        end
    endgenerate

    // R6
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_en |-> $onehot0(lk_hit_vec));

    // R5
    one_app_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_inc));

    // R2
    unsampled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_set[SAMPLE_BITS-1:0] != '0)) |=> !apply_en);

    // R10
    accept_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sampled |=> apply_en);

endmodule

// File: tb/contention_tagdir_tb.sv
module contention_tagdir_tb;

    localparam int NUM_APPS = 2;
    localparam int OUT_W    = 8;
    localparam int NVEC     = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [0:0]  acc_app = '0;
    logic [5:0]  acc_set = '0;
    logic [7:0]  acc_tag = '0;
    logic        acc_shared_miss = 1'b0;
    logic        interval_clr = 1'b0;
    logic [NUM_APPS*OUT_W-1:0] contention_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    contention_tagdir u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_valid       (acc_valid),
        .acc_app         (acc_app),
        .acc_set         (acc_set),
        .acc_tag         (acc_tag),
        .acc_shared_miss (acc_shared_miss),
        .interval_clr    (interval_clr),
        .contention_cnt  (contention_cnt)
    );

    // {app, set, tag, shared_miss, expected lane0, expected lane1}
    localparam logic [31:0] VECS [NVEC] = '{
        {1'b0, 6'd0, 8'd1,  1'b1, 8'd0,  8'd0},   // R1 cold shadow miss
        {1'b0, 6'd0, 8'd1,  1'b1, 8'd4,  8'd0},   // R3 contention
        {1'b0, 6'd0, 8'd1,  1'b0, 8'd4,  8'd0},   // R4 shared hit
        {1'b1, 6'd0, 8'd1,  1'b1, 8'd4,  8'd0},   // R5 other app cold
        {1'b1, 6'd0, 8'd1,  1'b1, 8'd4,  8'd4},   // R5 other app counts
        {1'b0, 6'd2, 8'd5,  1'b1, 8'd4,  8'd4},   // R2 unsampled
        {1'b0, 6'd2, 8'd5,  1'b1, 8'd4,  8'd4},   // R2 unsampled again
        {1'b0, 6'd4, 8'd10, 1'b1, 8'd4,  8'd4},   // R6 fill
        {1'b0, 6'd4, 8'd11, 1'b1, 8'd4,  8'd4},
        {1'b0, 6'd4, 8'd12, 1'b1, 8'd4,  8'd4},
        {1'b0, 6'd4, 8'd13, 1'b1, 8'd4,  8'd4},
        {1'b0, 6'd4, 8'd14, 1'b1, 8'd4,  8'd4},   // R6 evicts 10
        {1'b0, 6'd4, 8'd10, 1'b1, 8'd4,  8'd4},   // R4 evicted tag
        {1'b0, 6'd4, 8'd12, 1'b1, 8'd8,  8'd4},   // R3 still held
        {1'b0, 6'd4, 8'd11, 1'b1, 8'd8,  8'd4},   // R6 evicted 11
        {1'b0, 6'd8, 8'd20, 1'b0, 8'd8,  8'd4},   // R6 fill on shared hits
        {1'b0, 6'd8, 8'd21, 1'b0, 8'd8,  8'd4},
        {1'b0, 6'd8, 8'd22, 1'b0, 8'd8,  8'd4},
        {1'b0, 6'd8, 8'd23, 1'b0, 8'd8,  8'd4},
        {1'b0, 6'd8, 8'd20, 1'b0, 8'd8,  8'd4},   // R6 refresh 20
        {1'b0, 6'd8, 8'd24, 1'b0, 8'd8,  8'd4},   // R6 evicts 21
        {1'b0, 6'd8, 8'd20, 1'b1, 8'd12, 8'd4},   // R6 refreshed tag held
        {1'b0, 6'd8, 8'd21, 1'b1, 8'd12, 8'd4}    // R6 21 gone
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane(input int i);
        return contention_cnt[i*OUT_W +: OUT_W];
    endfunction

    task automatic access(input logic app, input logic [5:0] set,
                          input logic [7:0] tag, input logic miss);
        @(negedge clk);
        acc_valid = 1'b1; acc_app = app; acc_set = set;
        acc_tag = tag; acc_shared_miss = miss;
        @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lane(0), 8'd0, "R1 reset lane0");
        chk(lane(1), 8'd0, "R1 reset lane1");
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v][31], VECS[v][30:25], VECS[v][24:17], VECS[v][16]);
            chk(lane(0), VECS[v][15:8], $sformatf("R7 vec %0d lane0", v));
            chk(lane(1), VECS[v][7:0],  $sformatf("R7 vec %0d lane1", v));
        end

        // R9 clear alone
        @(negedge clk); interval_clr = 1'b1;
        @(negedge clk); interval_clr = 1'b0;
        chk(lane(0), 8'd0, "R9 clear lane0");
        chk(lane(1), 8'd0, "R9 clear lane1");

        // R9 directory survives clear: tag 20 still held in set 8
        access(1'b0, 6'd8, 8'd20, 1'b1);
        chk(lane(0), 8'd4, "R9 directory kept");

        // R9 clear on the apply edge of a counted access
        @(negedge clk);
        acc_valid = 1'b1; acc_app = 1'b0; acc_set = 6'd8;
        acc_tag = 8'd21; acc_shared_miss = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; interval_clr = 1'b1;
        @(negedge clk);
        interval_clr = 1'b0;
        chk(lane(0), 8'd4, "R9 coincident clear lane0");
        chk(lane(1), 8'd0, "R9 coincident clear lane1");

        // R10 latency: unchanged after first edge, counted after second
        @(negedge clk);
        acc_valid = 1'b1; acc_app = 1'b1; acc_set = 6'd0;
        acc_tag = 8'd1; acc_shared_miss = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(lane(1), 8'd0, "R10 not yet visible");
        @(negedge clk);
        chk(lane(1), 8'd4, "R10 visible after second edge");

        // R8 saturation with back-to-back accesses (R10 one per cycle)
        @(negedge clk);
        acc_valid = 1'b1;
        repeat (40) @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        chk(lane(1), 8'd164, "R10 back-to-back count");
        acc_valid = 1'b1;
        repeat (40) @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        chk(lane(1), 8'd252, "R8 saturated lane1");
        chk(lane(0), 8'd4,   "R5 lane0 untouched");

        @(negedge clk); interval_clr = 1'b1;
        @(negedge clk); interval_clr = 1'b0;
        chk(lane(1), 8'd0, "R9 clear after saturation");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule